// File: doc/BRIEF.md
# Four-Pair Complementary PWM Output Stage

This block drives eight PWM pins, grouped as four output pairs, from one free-running up-counter and four duty values. Pair k owns pins 2k+1 and 2k. The odd pin of a pair is the main output, taken from that pair's duty comparison. The even pin is meant for the lower switch of a half bridge.

Each pair has its own mode bit. With the bit at 0 the pair runs complementary: the even pin is the inverse of the odd pin, and an optional dead interval can force both pins low after every change of the comparison result. With the bit at 1 the pair runs independent: both pins carry the same comparison result and no dead interval is inserted. Period and duty values are taken in only when the counter wraps, so a write in the middle of a cycle cannot cause a glitch.

Top module: `cpwm_quad`

## Requirements
- R1: The internal counter steps by one each clock from 0 up to the active period and then returns to 0. With period P, each output pattern repeats every P+1 cycles.
- R2: Pin 2k+1 is high in the cycle after the counter value was less than pair k's active duty value, and low otherwise. There is one register between the count and the pin.
- R3: An active duty of 0 keeps pin 2k+1 low at all times. An active duty greater than the period keeps it high at all times.
- R4: When mode bit k is 0 (complementary) and no dead interval is running, pin 2k is the inverse of pin 2k+1. In this mode the two pins are never high together.
- R5: In complementary mode with the dead-time enable at 1 and a dead count D greater than 0, every change of the pair's comparison result holds both pins low for exactly D cycles. The new level then appears. A change during a running interval starts it again. With D = 0, or with the enable at 0, no interval is inserted.
- R6: When mode bit k is 1 (independent), pin 2k equals pin 2k+1, and no dead interval is applied.
- R7: New period and duty input values take effect only from the count that follows a wrap. Input changes at any other time have no effect on the outputs until then.
- R8: While reset is asserted, all eight pins are low and the dead timers are cleared. The reset cycle loads the current period and duty inputs as active values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | 12 | Counter terminal value |
| duty_i | input | 48 | Four 12-bit duty values; pair k in bits [12k+11:12k] |
| mode_i | input | 4 | Per-pair mode: 0 complementary, 1 independent |
| dt_en_i | input | 1 | Dead-time enable |
| dt_len_i | input | 8 | Dead interval in clock cycles |
| pwm_o | output | 8 | PWM pins; pair k on bits 2k+1 (main) and 2k (partner) |

## Verification
Three events can fall in the same cycle: the counter wrap that loads new period and duty values, a comparison edge, and a dead interval that is still running. The sweep changes inputs at arbitrary points within each period, with short periods and dead counts as long as a whole period. This makes edges land on wrap cycles and inside running intervals. A cycle-exact arithmetic model in the bench predicts all eight pins on every clock. Each mismatch is attributed to shadow loading, dead time, mode or comparison according to the model's state in that cycle.

// File: rtl/cpwm_pkg.sv
// Package: shared defaults and the per-pair mode encoding for the
// four-pair PWM output stage.
// Assumes: all modules take their default widths from here.
package cpwm_pkg;
    localparam int CNT_W_DEF = 12;
    localparam int DT_W_DEF  = 8;
    localparam int PAIRS_DEF = 4;

    typedef enum logic {
        MODE_COMPL = 1'b0,
        MODE_INDEP = 1'b1
    } pair_mode_e;
endpackage

// File: rtl/cpwm_timebase.sv
// Module: cpwm_timebase
// Free-running up-counter from 0 to the active period. Period and all
// duty values are shadowed and reloaded only on the wrap cycle, so that
// the new values apply from count 0.
// Assumes: synchronous active-low reset, during which the shadows load
// the current inputs.
module cpwm_timebase
    import cpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int PAIRS = PAIRS_DEF,
    localparam int DUTY_W = CNT_W * PAIRS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [DUTY_W-1:0] duty_act_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  per_q;
    logic [DUTY_W-1:0] duty_q;
    logic              wrap;

    // Terminal count reached: return to zero and reload shadows.
    assign wrap = (cnt_q >= per_q);

    // Count, wrap, and shadow reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= period_i;
            duty_q <= duty_i;
        end else if (wrap) begin
            cnt_q  <= '0;
            per_q  <= period_i;
            duty_q <= duty_i;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o      = cnt_q;
    assign duty_act_o = duty_q;

    // R1: counter never passes the active period
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_q);

    // R1: terminal count is followed by zero
    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == per_q) |=> (cnt_q == '0));

    // R7: shadows only change on a wrap
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(per_q) && $stable(duty_q)));
endmodule

// File: rtl/cpwm_compare.sv
// Module: cpwm_compare
// Duty comparator for one pair: result is high while the count is below
// the active duty value.
// Assumes: count and duty share one width; purely combinational.
module cpwm_compare
    import cpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             match_o
);
    // Main-output comparison.
    always_comb begin
        match_o = (cnt_i < duty_i);
    end
endmodule

// File: rtl/cpwm_deadband.sv
// Module: cpwm_deadband
// Output stage of one pair. Complementary mode drives the partner pin
// inverted and, when enabled, holds both pins low for dt_len_i cycles
// after each change of the comparison result. Independent mode copies
// the result to both pins without any dead interval.
// Assumes: raw_i is the combinational compare result; pins are registered.
module cpwm_deadband
    import cpwm_pkg::*;
#(
    parameter int DT_W = DT_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_i,
    input  logic            mode_i,
    input  logic            dt_en_i,
    input  logic [DT_W-1:0] dt_len_i,
    output logic            hi_o,
    output logic            lo_o
);
    logic            prev_q;
    logic [DT_W-1:0] tmr_q;
    logic            hi_q;
    logic            lo_q;
    logic            sw_edge;
    logic            compl;
    logic            arm;
    logic            gate;

    // Edge detection, interval start, and output permission.
    always_comb begin
        sw_edge = raw_i ^ prev_q;
        compl   = (mode_i == MODE_COMPL);
        arm     = sw_edge && compl && dt_en_i && (dt_len_i != '0);
        gate    = sw_edge ? !arm : (tmr_q <= DT_W'(1));
    end

    // Previous compare level, dead timer, and registered pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            tmr_q  <= '0;
            hi_q   <= 1'b0;
            lo_q   <= 1'b0;
        end else begin
            prev_q <= raw_i;
            if (!compl) begin
                tmr_q <= '0;
                hi_q  <= raw_i;
                lo_q  <= raw_i;
            end else begin
                if (sw_edge)
                    tmr_q <= arm ? dt_len_i : '0;
                else if (tmr_q != '0)
                    tmr_q <= tmr_q - DT_W'(1);
                hi_q <= raw_i & gate;
                lo_q <= ~raw_i & gate;
            end
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // R4: complementary pins never both high
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_COMPL) |=> !(hi_q && lo_q));

    // R5: a running interval without a new edge keeps both pins low
    p_dead_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (compl && !sw_edge && tmr_q > DT_W'(1)) |=> (!hi_q && !lo_q));

    // R6: independent mode drives both pins alike
    p_indep_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_INDEP) |=> (hi_q == lo_q));
endmodule

// File: rtl/cpwm_quad.sv
// Module: cpwm_quad
// Four-pair PWM output stage: one shared time base, one comparator and
// one dead-band stage per pair. Pair k drives pins 2k+1 (main) and 2k.
// Assumes: synchronous active-low reset; inputs are synchronous to clk.
module cpwm_quad
    import cpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int DT_W  = DT_W_DEF,
    parameter int PAIRS = PAIRS_DEF,
    localparam int DUTY_W = CNT_W * PAIRS,
    localparam int PINS   = 2 * PAIRS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [PAIRS-1:0]  mode_i,
    input  logic              dt_en_i,
    input  logic [DT_W-1:0]   dt_len_i,
    output logic [PINS-1:0]   pwm_o
);
    logic [CNT_W-1:0]  cnt;
    logic [DUTY_W-1:0] duty_act;
    logic [PAIRS-1:0]  match;

    cpwm_timebase #(.CNT_W(CNT_W), .PAIRS(PAIRS)) tb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_i   (period_i),
        .duty_i     (duty_i),
        .cnt_o      (cnt),
        .duty_act_o (duty_act)
    );

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        cpwm_compare #(.CNT_W(CNT_W)) cmp_i (
            .cnt_i   (cnt),
            .duty_i  (duty_act[k*CNT_W +: CNT_W]),
            .match_o (match[k])
        );

        cpwm_deadband #(.DT_W(DT_W)) db_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (match[k]),
            .mode_i   (mode_i[k]),
            .dt_en_i  (dt_en_i),
            .dt_len_i (dt_len_i),
            .hi_o     (pwm_o[2*k+1]),
            .lo_o     (pwm_o[2*k])
        );
    end

    // R8: a reset cycle leaves every pin low
    p_reset_low_r8: assert property (@(posedge clk)
        !rst_n |=> (pwm_o == '0));
endmodule

// File: tb/cpwm_quad_tb_top.sv
module cpwm_quad_tb_top;
    localparam int CW = 12;
    localparam int DW = 8;
    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   period_i = '0;
    logic [CW*NP-1:0] duty_i = '0;
    logic [NP-1:0]   mode_i = '0;
    logic            dt_en_i = 1'b0;
    logic [DW-1:0]   dt_len_i = '0;
    logic [2*NP-1:0] pwm_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    int m_cnt, m_per;
    int m_duty [NP];
    int m_prev [NP];
    int m_tmr  [NP];
    logic [2*NP-1:0] exp_o;
    string tag_hi [NP];
    string tag_lo [NP];

    cpwm_quad dut_i (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
        .mode_i(mode_i), .dt_en_i(dt_en_i), .dt_len_i(dt_len_i), .pwm_o(pwm_o)
    );

    always #5 clk = ~clk;

    function automatic int duty_in(input int k);
        return int'(duty_i[k*CW +: CW]);
    endfunction

    // Advance one clock: model the edge, then compare pins 1 ns later.
    task automatic tick();
        bit shadow_diff;
        @(posedge clk);
        shadow_diff = (m_per != int'(period_i));
        for (int k = 0; k < NP; k++)
            if (m_duty[k] != duty_in(k)) shadow_diff = 1;
        if (!rst_n) begin
            exp_o = '0;
            for (int k = 0; k < NP; k++) begin
                m_prev[k] = 0; m_tmr[k] = 0; m_duty[k] = duty_in(k);
                tag_hi[k] = "R8"; tag_lo[k] = "R8";
            end
            m_cnt = 0; m_per = int'(period_i);
        end else begin
            for (int k = 0; k < NP; k++) begin
                int raw, edg, arm, gate;
                raw = (m_cnt < m_duty[k]) ? 1 : 0;
                edg = (raw != m_prev[k]) ? 1 : 0;
                if (mode_i[k]) begin
                    exp_o[2*k+1] = raw[0]; exp_o[2*k] = raw[0]; m_tmr[k] = 0;
                    tag_hi[k] = "R6"; tag_lo[k] = "R6";
                end else begin
                    arm  = (edg != 0 && dt_en_i && dt_len_i != 0) ? 1 : 0;
                    gate = (edg != 0) ? (arm == 0 ? 1 : 0) : (m_tmr[k] <= 1 ? 1 : 0);
                    if (edg != 0) m_tmr[k] = arm != 0 ? int'(dt_len_i) : 0;
                    else if (m_tmr[k] > 0) m_tmr[k] = m_tmr[k] - 1;
                    exp_o[2*k+1] = (raw != 0 && gate != 0);
                    exp_o[2*k]   = (raw == 0 && gate != 0);
                    if (gate == 0) begin tag_hi[k] = "R5"; tag_lo[k] = "R5"; end
                    else begin
                        tag_hi[k] = (m_duty[k] == 0 || m_duty[k] > m_per) ? "R3" : "R1 R2";
                        tag_lo[k] = "R4";
                    end
                end
                if (shadow_diff) begin
                    tag_hi[k] = {"R7 ", tag_hi[k]}; tag_lo[k] = {"R7 ", tag_lo[k]};
                end
                m_prev[k] = raw;
            end
            if (m_cnt >= m_per) begin
                m_cnt = 0; m_per = int'(period_i);
                for (int k = 0; k < NP; k++) m_duty[k] = duty_in(k);
            end else m_cnt = m_cnt + 1;
        end
        #1;
        for (int k = 0; k < NP; k++) begin
            checks++;
            if (pwm_o[2*k+1] !== exp_o[2*k+1]) begin
                fails++;
                $display("FAIL %s pin %0d: got %b expected %b at %0t",
                         tag_hi[k], 2*k+1, pwm_o[2*k+1], exp_o[2*k+1], $time);
            end
            checks++;
            if (pwm_o[2*k] !== exp_o[2*k]) begin
                fails++;
                $display("FAIL %s pin %0d: got %b expected %b at %0t",
                         tag_lo[k], 2*k, pwm_o[2*k], exp_o[2*k], $time);
            end
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        // R8: reset state
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        // Sweep period, duty pattern, dead-time setting and mode pattern.
        // Inputs change mid-period, exercising shadow loading (R7).
        for (int p = 0; p < 8; p++) begin
            for (int dp = 0; dp < 6; dp++) begin
                for (int dt = 0; dt < 5; dt++) begin
                    if (p == 4 && dp == 0 && dt == 0) begin
                        rst_n = 1'b0;           // R8: mid-run reset
                        repeat (2) tick();
                        rst_n = 1'b1;
                    end
                    period_i = CW'(p);
                    for (int k = 0; k < NP; k++)
                        duty_i[k*CW +: CW] = CW'((dp + 2*k + dt) % (p + 3));
                    mode_i   = NP'(dp * 5 + dt * 3 + p);
                    dt_en_i  = (dt != 0);
                    dt_len_i = DW'(dt == 0 ? 2 : dt - 1);
                    repeat (2 * (p + 1) + 5) tick();
                end
            end
        end
        // R5: long dead interval spanning whole periods, all complementary
        mode_i = '0; dt_en_i = 1'b1; dt_len_i = DW'(9); period_i = CW'(3);
        for (int k = 0; k < NP; k++) duty_i[k*CW +: CW] = CW'(k + 1);
        repeat (40) tick();
        report();
    end

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule